// File: doc/BRIEF.md
# Sync-Width Horizontal Offset Aligner

This block locates where active pixels begin on each video line. It watches a composite sync input for a low pulse, times that pulse in reference clock cycles, and sorts the width into one of three bins (short, nominal, long). The bin nudges a configured horizontal offset by zero, one or two steps. Each step is half a character, which gives fine sideways scrolling. The block then counts transitions of both polarities on a pixel-sync input until the adjusted offset is used up. At that point it emits a one-cycle start-of-capture pulse.

A line timeout keeps the block moving when sync is absent or stuck: a wait that lasts too long counts as satisfied. Three mode inputs shape the behaviour:
- a legacy-hardware mode inverts the width binning and requires every pixel-sync transition to be seen twice in a row;
- a scroll-disable mode leaves the offset untouched;
- a fast mode accepts a sync level after a single sample instead of two.

After each start pulse the block returns to waiting for the next sync pulse.

Top module: `hsync_offset_aligner`

## Requirements
- R1: `width_o` reports the length of the low sync pulse in clock cycles, counted from the cycle the low level is accepted to the cycle the high level is accepted. It only changes when the high level is accepted, and holds its value otherwise.
- R2: In normal mode the adjustment is the number of thresholds the width is strictly below. The two thresholds are NOMINAL+MARGIN and NOMINAL-MARGIN. A short pulse therefore adds 2, a nominal one adds 1 and a long one adds 0.
- R3: In legacy mode (`legacy_i`=1) the adjustment is the number of thresholds the width strictly exceeds.
- R4: With `scroll_off_i`=1 the applied offset equals `offset_cfg_i`, whatever the width.
- R5: With `fast_i`=0 a sync level is accepted only after two consecutive matching samples, so a single-cycle low glitch is ignored. With `fast_i`=1 one sample suffices.
- R6: Once a sync wait has lasted TIMEOUT cycles, every further sample counts as matching. A stuck-low sync therefore yields a width of TIMEOUT+2 (or TIMEOUT+1 in fast mode). A stuck-high sync still produces a start pulse.
- R7: After the high level is accepted, the expected pixel-sync level is 0. Each accepted match toggles the expected level and counts one transition. The start pulse appears in the cycle after the transition that exhausts the offset. An offset of 0 behaves as 1.
- R8: In legacy mode each pixel-sync transition is accepted only on its second consecutive matching sample, which delays the start pulse by one cycle.
- R9: `start_o` is high for exactly one cycle per line. `offset_o` and `width_o` are valid while it is high.
- R10: The adjusted offset saturates at 2^OFS_W-1.
- R11: After reset `start_o`, `offset_o` and `width_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (one cycle per width unit) |
| rst_n | input | 1 | Active-low synchronous reset |
| csync_i | input | 1 | Composite sync, low during the line pulse |
| psync_i | input | 1 | Pixel-sync input whose transitions are counted |
| offset_cfg_i | input | OFS_W | Configured horizontal offset in transitions |
| legacy_i | input | 1 | Legacy hardware: inverted binning, double-sampled transitions |
| scroll_off_i | input | 1 | Disable width-based offset adjustment |
| fast_i | input | 1 | Accept sync levels after one sample |
| start_o | output | 1 | One-cycle start-of-capture pulse |
| offset_o | output | OFS_W | Offset applied to the most recent line |
| width_o | output | WIDTH_W | Measured low-pulse width of the most recent line |

## Verification
The interesting overlap is the line timeout expiring in the same cycle as the sync level that would have ended the wait anyway. A pulse exactly TIMEOUT+1 cycles long makes both causes of acceptance coincide; the bench expects the width to equal the pulse length rather than a timeout value. A second overlap is the width landing exactly on a threshold while legacy mode and saturation are active; the bench drives both threshold values and offsets near the top of the range in both modes. Random lines mix all mode flags and compare the start cycle, width and offset against bench functions.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HIGH = 2'd1,
        ST_SKIP = 2'd2
    } align_state_e;

endpackage

// File: rtl/hsa_sample_qual.sv
module hsa_sample_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic hit_i,
    input  logic need_two_i,
    output logic qual_o
);
    logic run_d, run_q;

    always_comb begin
        qual_o = active_i && hit_i && (!need_two_i || run_q);
        run_d  = active_i && hit_i && !qual_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/hsa_timer.sv
module hsa_timer #(
    parameter int WIDTH_W = 16,
    parameter int TIMEOUT = 6000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    output logic [WIDTH_W-1:0] count_o,
    output logic               expired_o
);
    localparam logic [WIDTH_W-1:0] LIMIT = WIDTH_W'(TIMEOUT);

    logic [WIDTH_W-1:0] count_d, count_q;

    always_comb begin
        if (clear_i)               count_d = '0;
        else if (count_q == '1)    count_d = count_q;
        else                       count_d = count_q + 1'b1;
        count_o   = count_q;
        expired_o = (count_q >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    a_r6_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0));
endmodule

// File: rtl/hsa_width_binner.sv
module hsa_width_binner #(
    parameter int OFS_W   = 8,
    parameter int WIDTH_W = 16,
    parameter int NOMINAL = 4000,
    parameter int MARGIN  = 224
) (
    input  logic [WIDTH_W-1:0] width_i,
    input  logic [OFS_W-1:0]   base_i,
    input  logic               legacy_i,
    input  logic               scroll_off_i,
    output logic [OFS_W-1:0]   adj_o
);
    localparam logic [WIDTH_W-1:0] TH_UP = WIDTH_W'(NOMINAL + MARGIN);
    localparam logic [WIDTH_W-1:0] TH_DN = WIDTH_W'(NOMINAL - MARGIN);

    logic [1:0]     step;
    logic [OFS_W:0] sum;

    always_comb begin
        step = 2'd0;
        if (!scroll_off_i) begin
            if (legacy_i)
                step = {1'b0, width_i > TH_UP} + {1'b0, width_i > TH_DN};
            else
                step = {1'b0, width_i < TH_UP} + {1'b0, width_i < TH_DN};
        end
        sum   = {1'b0, base_i} + {{(OFS_W-1){1'b0}}, step};
        adj_o = sum[OFS_W] ? {OFS_W{1'b1}} : sum[OFS_W-1:0];
    end
endmodule

// File: rtl/hsync_offset_aligner.sv
module hsync_offset_aligner #(
    parameter int OFS_W   = 8,
    parameter int WIDTH_W = 16,
    parameter int NOMINAL = 4000,
    parameter int MARGIN  = 224,
    parameter int TIMEOUT = 6000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csync_i,
    input  logic               psync_i,
    input  logic [OFS_W-1:0]   offset_cfg_i,
    input  logic               legacy_i,
    input  logic               scroll_off_i,
    input  logic               fast_i,
    output logic               start_o,
    output logic [OFS_W-1:0]   offset_o,
    output logic [WIDTH_W-1:0] width_o
);
    import hsa_pkg::*;

    localparam logic [WIDTH_W-1:0] WAIT_MAX = WIDTH_W'(TIMEOUT + 1);

    typedef struct packed {
        align_state_e       state;
        logic               exp_lvl;
        logic [OFS_W-1:0]   remain;
        logic [OFS_W-1:0]   ofs;
        logic [WIDTH_W-1:0] width;
        logic               start;
    } regs_t;

    regs_t r_d, r_q;

    logic               cs_active, cs_hit, cs_qual;
    logic               ps_active, ps_hit, ps_qual;
    logic               last_edge, tmr_clear, tmr_expired;
    logic [WIDTH_W-1:0] tmr_count, width_next;
    logic [OFS_W-1:0]   adj_ofs;

    // sync level qualification and elapsed-time tracking
    always_comb begin
        cs_active  = (r_q.state != ST_SKIP);
        cs_hit     = ((r_q.state == ST_LOW) ? !csync_i : csync_i) || tmr_expired;
        ps_active  = (r_q.state == ST_SKIP);
        ps_hit     = (psync_i == r_q.exp_lvl);
        last_edge  = ps_qual && (r_q.remain == {{(OFS_W-1){1'b0}}, 1'b1});
        tmr_clear  = cs_qual || last_edge;
        width_next = (tmr_count == '1) ? tmr_count : tmr_count + 1'b1;
    end

    hsa_sample_qual u_cs_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (cs_active),
        .hit_i     (cs_hit),
        .need_two_i(!fast_i),
        .qual_o    (cs_qual)
    );

    hsa_sample_qual u_ps_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (ps_active),
        .hit_i     (ps_hit),
        .need_two_i(legacy_i),
        .qual_o    (ps_qual)
    );

    hsa_timer #(
        .WIDTH_W(WIDTH_W),
        .TIMEOUT(TIMEOUT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (tmr_clear),
        .count_o  (tmr_count),
        .expired_o(tmr_expired)
    );

    hsa_width_binner #(
        .OFS_W  (OFS_W),
        .WIDTH_W(WIDTH_W),
        .NOMINAL(NOMINAL),
        .MARGIN (MARGIN)
    ) u_binner (
        .width_i     (width_next),
        .base_i      (offset_cfg_i),
        .legacy_i    (legacy_i),
        .scroll_off_i(scroll_off_i),
        .adj_o       (adj_ofs)
    );

    // next-state computation
    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        unique case (r_q.state)
            ST_LOW: begin
                if (cs_qual) r_d.state = ST_HIGH;
            end
            ST_HIGH: begin
                if (cs_qual) begin
                    r_d.state   = ST_SKIP;
                    r_d.width   = width_next;
                    r_d.ofs     = adj_ofs;
                    r_d.remain  = (adj_ofs == '0) ? {{(OFS_W-1){1'b0}}, 1'b1} : adj_ofs;
                    r_d.exp_lvl = 1'b0;
                end
            end
            ST_SKIP: begin
                if (ps_qual) begin
                    r_d.exp_lvl = !r_q.exp_lvl;
                    if (last_edge) begin
                        r_d.start = 1'b1;
                        r_d.state = ST_LOW;
                    end else begin
                        r_d.remain = r_q.remain - 1'b1;
                    end
                end
            end
            default: r_d.state = ST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_LOW;
            r_q.exp_lvl <= 1'b0;
            r_q.remain  <= '0;
            r_q.ofs     <= '0;
            r_q.width   <= '0;
            r_q.start   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_o  = r_q.start;
    assign offset_o = r_q.ofs;
    assign width_o  = r_q.width;

    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    a_r9_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (r_q.state == ST_LOW));

    a_r1_width_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_HIGH) |=> $stable(width_o));

    a_r7_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SKIP) |-> (r_q.remain != '0));

    a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_SKIP) |-> (tmr_count <= WAIT_MAX));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HIGH && cs_qual && scroll_off_i) |=> (offset_o == $past(offset_cfg_i)));
endmodule

// File: tb/hsync_offset_aligner_test.sv
module hsync_offset_aligner_test;
    localparam int OFS_W = 8;
    localparam int WW    = 16;
    localparam int NOM   = 40;
    localparam int MRG   = 4;
    localparam int TMO   = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync = 1'b1, psync = 1'b1;
    logic [OFS_W-1:0] cfg = '0;
    logic legacy = 1'b0, soff = 1'b0, fast = 1'b0;
    logic start;
    logic [OFS_W-1:0] ofs;
    logic [WW-1:0] width;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hsync_offset_aligner #(
        .OFS_W(OFS_W), .WIDTH_W(WW), .NOMINAL(NOM), .MARGIN(MRG), .TIMEOUT(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .csync_i(csync), .psync_i(psync),
        .offset_cfg_i(cfg), .legacy_i(legacy), .scroll_off_i(soff), .fast_i(fast),
        .start_o(start), .offset_o(ofs), .width_o(width)
    );

    function automatic int exp_width(int len, bit f);
        int lim = f ? TMO + 1 : TMO + 2;
        return (len < lim) ? len : lim;
    endfunction

    function automatic int exp_ofs(int w, int base, bit leg, bit so);
        int add = 0;
        if (!so) begin
            if (leg) add = int'(w > NOM + MRG) + int'(w > NOM - MRG);
            else     add = int'(w < NOM + MRG) + int'(w < NOM - MRG);
        end
        return (base + add > 255) ? 255 : base + add;
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // one line: sync high lead, optional glitch, low pulse of len, then pixel-sync toggles
    task automatic run_line(int len, int base, bit leg, bit so, bit f, int per, bit glitch);
        int t0 = 6;
        int tp0 = t0 + len + 4;
        int w = exp_width(len, f);
        int o = exp_ofs(w, base, leg, so);
        int k = (o == 0) ? 1 : o;
        int e = tp0 + (k - 1) * per + (leg ? 1 : 0);
        int stray = 0;
        for (int i = 0; i <= e + 2; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (i - 1 == e) begin
                    check("R7/R8/R9 start cycle", int'(start), 1);
                    check(leg ? "R3 width bin legacy" : (so ? "R4 scroll off" : "R2 width bin"), int'(ofs), o);
                    check((len > TMO) ? "R6 timeout width" : "R1/R5 width", int'(width), w);
                end else if (start) begin
                    stray++;
                end
            end
            if (i == 0) begin
                cfg = OFS_W'(base); legacy = leg; soff = so; fast = f;
            end
            csync = !((i >= t0 && i < t0 + len) || (glitch && i == 2));
            psync = (i < tp0) ? 1'b1 : ((((i - tp0) / per) % 2) == 0 ? 1'b0 : 1'b1);
        end
        check("R9 no stray start", stray, 0);
    endtask

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R11 reset start", int'(start), 0);
        check("R11 reset offset", int'(ofs), 0);
        check("R11 reset width", int'(width), 0);
        rst_n = 1'b1;

        // R6: no sync at all, pixel sync toggling; low wait must time out
        begin
            int seen = 0;
            for (int i = 0; i < 400 && seen == 0; i++) begin
                @(negedge clk);
                if (start) seen = 1;
                psync = ((i / 2) % 2) == 0;
            end
            check("R6 stuck-high sync still starts", seen, 1);
            check("R6 stuck-high width", int'(width), 2);
            check("R2 short bin after timeout", int'(ofs), 2);
        end

        // directed corners
        run_line(NOM + MRG,     3, 0, 0, 0, 2, 0);   // R2 on upper threshold
        run_line(NOM - MRG,     3, 0, 0, 0, 2, 0);   // R2 on lower threshold
        run_line(NOM - MRG - 1, 3, 0, 0, 0, 3, 0);   // R2 short
        run_line(NOM + MRG + 1, 3, 0, 0, 0, 3, 0);   // R2 long
        run_line(NOM + MRG,     3, 1, 0, 0, 2, 0);   // R3 on upper threshold
        run_line(NOM - MRG,     3, 1, 0, 0, 2, 0);   // R3 on lower threshold
        run_line(NOM + MRG + 1, 3, 1, 0, 0, 3, 0);   // R3 long
        run_line(20,            5, 0, 1, 0, 2, 0);   // R4 scroll off
        run_line(30,            4, 0, 0, 0, 2, 1);   // R5 glitch ignored
        run_line(30,            4, 0, 0, 1, 2, 0);   // R5 fast
        run_line(TMO + 1,       2, 0, 0, 0, 2, 0);   // R6 timeout coincides with level
        run_line(TMO + 15,      2, 0, 0, 0, 2, 0);   // R6 stuck low
        run_line(TMO + 15,      2, 0, 0, 1, 2, 0);   // R6 fast stuck low
        run_line(NOM + MRG + 2, 0, 0, 0, 0, 2, 0);   // R7 zero offset as one
        run_line(NOM - MRG - 4, 254, 0, 0, 0, 2, 0); // R10 saturation
        run_line(NOM - MRG - 4, 255, 1, 0, 0, 2, 0); // R10 legacy near top
        run_line(NOM,           6, 1, 0, 0, 4, 0);   // R8 double-sampled edges

        // constrained random lines
        for (int n = 0; n < 30; n++) begin
            int len  = 3 + int'($urandom_range(0, 67));
            int base = ($urandom_range(0, 9) == 0) ? 250 + int'($urandom_range(0, 5))
                                                   : int'($urandom_range(0, 7));
            bit leg  = 1'($urandom_range(0, 1));
            bit so   = ($urandom_range(0, 4) == 0);
            bit f    = 1'($urandom_range(0, 1));
            int per  = 2 + int'($urandom_range(0, 2));
            if ($urandom_range(0, 5) == 0) len = TMO + 5;
            run_line(len, base, leg, so, f, per, (!f && $urandom_range(0, 3) == 0));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule